// File: doc/BRIEF.md
# Priority Pad Function Router

This block decides, for every pad in a bank, which on-chip function drives it. Software sets per-pin bits in five independent function-select masks over a small register bus. For each pin a fixed precedence among those masks picks one owner. The owner's data and output-enable then drive the pad. A pin with no select bit set is left to the general-purpose I/O logic. Because the masks are independent, a pin may have several select bits set at once; the precedence settles the conflict without any error.

The select masks can be loaded with a full-word write, or changed with set-mask and clear-mask operations that touch only the bits given. A sixth mask, in the same register space, holds the pull-up enables for the pads. The incoming pad level is passed unchanged to every function. A packed 3-bit code per pin reports which function currently owns each pad.

Top module: `padfn_router`

## Requirements
- R1: After synchronous reset, every mask register reads 0, every pin code is 0, `pad_pu` is 0, and `pad_do`/`pad_oe` equal `gpio_do`/`gpio_oe`.
- R2: A bus write with op 0 (full write) loads `bus_wdata` into the register at the given byte offset (0x14 secondary, 0x8C tertiary, 0x94 quaternary, 0x9C debug, 0xA4 alternative, 0xAC pull-up) on the next rising clock edge.
- R3: Op 1 (set-mask) sets exactly the register bits that are 1 in `bus_wdata`, and op 2 (clear-mask) clears exactly those bits. All other bits are left as they were. Op 3 changes nothing.
- R4: When several select bits are set for a pin, the owner is secondary first, then tertiary, quaternary, debug, and alternative last. When none is set, GPIO owns the pin.
- R5: `fn_code[3*i+2:3*i]` reports the owner of pin i: 0 GPIO, 1 secondary, 2 tertiary, 3 quaternary, 4 debug, 5 alternative.
- R6: `pad_do[i]` and `pad_oe[i]` equal the owner's data and enable bits for pin i. They follow source changes and mask changes combinationally, with no clock delay.
- R7: `periph_di` equals `pad_di` at all times, whatever the owner.
- R8: `pad_pu` equals the pull-up register at offset 0xAC.
- R9: When `bus_re` is high at a rising edge, `bus_rdata` shows the addressed register from that edge on. An unmapped offset reads 0.
- R10: A write to an offset outside the six listed leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_op | input | 2 | Write operation: 0 full, 1 set-mask, 2 clear-mask, 3 none |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | NUM_PINS | Write data / bit mask |
| bus_rdata | output | NUM_PINS | Registered read data |
| gpio_do | input | NUM_PINS | GPIO pad data |
| gpio_oe | input | NUM_PINS | GPIO pad enable |
| sec_do | input | NUM_PINS | Secondary function data |
| sec_oe | input | NUM_PINS | Secondary function enable |
| ter_do | input | NUM_PINS | Tertiary function data |
| ter_oe | input | NUM_PINS | Tertiary function enable |
| qua_do | input | NUM_PINS | Quaternary function data |
| qua_oe | input | NUM_PINS | Quaternary function enable |
| dbg_do | input | NUM_PINS | Debug function data |
| dbg_oe | input | NUM_PINS | Debug function enable |
| alt_do | input | NUM_PINS | Alternative function data |
| alt_oe | input | NUM_PINS | Alternative function enable |
| pad_di | input | NUM_PINS | Level sampled at the pads |
| pad_do | output | NUM_PINS | Data driven to the pads |
| pad_oe | output | NUM_PINS | Output enable to the pads |
| pad_pu | output | NUM_PINS | Pull-up enable to the pads |
| periph_di | output | NUM_PINS | Pad level broadcast to all functions |
| fn_code | output | 3*NUM_PINS | Owner code per pin |

## Verification
Assertions check the register operations on every cycle. After a set-mask or clear-mask, only the masked bits may move. Op 3 and unmapped writes must leave every register still. A read must return the register's value from the edge before. Per pin, they also check that a set secondary bit always wins, that the tertiary-over-lower order holds, and that an empty selection routes the GPIO source to the pad. Some behaviour only the bench's scenarios can show. These are the full precedence table across all 32 combinations of select bits, the code packing, the same-cycle response of the pad outputs to source changes, the pull-up path, and the reset values.

// File: rtl/padfn_pkg.sv
package padfn_pkg;
  localparam int NUM_FN  = 5;
  localparam int CODE_W  = 3;
  localparam int NUM_REG = NUM_FN + 1;
  localparam int PU_IDX  = NUM_FN;

  typedef enum logic [CODE_W-1:0] {
    FN_GPIO = 3'd0,
    FN_SEC  = 3'd1,
    FN_TER  = 3'd2,
    FN_QUA  = 3'd3,
    FN_DBG  = 3'd4,
    FN_ALT  = 3'd5
  } fn_code_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } bus_op_e;

  // Register index 0..4 are the select masks in precedence order, 5 is pull-up
  function automatic logic [7:0] reg_offset(int idx);
    case (idx)
      0:       return 8'h14;
      1:       return 8'h8C;
      2:       return 8'h94;
      3:       return 8'h9C;
      4:       return 8'hA4;
      default: return 8'hAC;
    endcase
  endfunction
endpackage

// File: rtl/padfn_regs.sv
module padfn_regs
  import padfn_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          re,
  input  logic [1:0]                    op,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_PINS-1:0]           wdata,
  output logic [NUM_PINS-1:0]           rdata,
  output logic [NUM_FN-1:0][NUM_PINS-1:0] sel_o,
  output logic [NUM_PINS-1:0]           pu_o
);
  logic [NUM_PINS-1:0] regs_q [NUM_REG];
  logic [NUM_REG-1:0]  hit;
  logic                any_hit;
  logic [NUM_PINS-1:0] rd_mux;

  assign any_hit = |hit;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    assign hit[g] = (addr == ADDR_W'(reg_offset(g)));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (we && hit[g]) begin
        case (bus_op_e'(op))
          OP_WRITE: regs_q[g] <= wdata;
          OP_SET:   regs_q[g] <= regs_q[g] | wdata;
          OP_CLEAR: regs_q[g] <= regs_q[g] & ~wdata;
          default:  regs_q[g] <= regs_q[g];
        endcase
      end
    end

    // R2: full write lands next edge
    p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
      (we && op == OP_WRITE && hit[g]) |=> regs_q[g] == $past(wdata));
    // R3: set-mask raises masked bits, keeps the rest
    p_set_mask_r3: assert property (@(posedge clk) disable iff (rst)
      (we && op == OP_SET && hit[g]) |=>
        ((regs_q[g] & $past(wdata)) == $past(wdata)) &&
        ((regs_q[g] & ~$past(wdata)) == ($past(regs_q[g]) & ~$past(wdata))));
    // R3: clear-mask drops masked bits, keeps the rest
    p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
      (we && op == OP_CLEAR && hit[g]) |=>
        ((regs_q[g] & $past(wdata)) == '0) &&
        ((regs_q[g] & ~$past(wdata)) == ($past(regs_q[g]) & ~$past(wdata))));
    // R3: op 3 leaves the register alone
    p_noop_r3: assert property (@(posedge clk) disable iff (rst)
      (we && op == OP_NONE) |=> $stable(regs_q[g]));
    // R10: unmapped writes change nothing
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
      (we && !any_hit) |=> $stable(regs_q[g]));
    // R9: read returns the value held at the read edge
    p_readback_r9: assert property (@(posedge clk) disable iff (rst)
      (re && hit[g]) |=> rdata == $past(regs_q[g]));
  end

  for (genvar f = 0; f < NUM_FN; f++) begin : g_sel
    assign sel_o[f] = regs_q[f];
  end
  assign pu_o = regs_q[PU_IDX];

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REG; k++) begin
      if (hit[k]) rd_mux = regs_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/padfn_pin.sv
module padfn_pin
  import padfn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FN-1:0] sel,
  input  logic [NUM_FN:0]   src_do,
  input  logic [NUM_FN:0]   src_oe,
  output logic              pad_do,
  output logic              pad_oe,
  output logic [CODE_W-1:0] code
);
  // Walk from lowest precedence up so the highest set bit is written last
  always_comb begin
    code = FN_GPIO;
    for (int k = NUM_FN - 1; k >= 0; k--) begin
      if (sel[k]) code = CODE_W'(k + 1);
    end
  end

  assign pad_do = src_do[code];
  assign pad_oe = src_oe[code];

  // R4: secondary always wins
  p_sec_wins_r4: assert property (@(posedge clk) disable iff (rst)
    sel[0] |-> (code == FN_SEC && pad_do == src_do[1] && pad_oe == src_oe[1]));
  // R4: tertiary beats every lower select
  p_ter_order_r4: assert property (@(posedge clk) disable iff (rst)
    (sel[1] && !sel[0]) |-> code == FN_TER);
  // R4/R6: empty selection hands the pad to GPIO
  p_gpio_default_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (code == FN_GPIO && pad_do == src_do[0] && pad_oe == src_oe[0]));
  // R5: code never leaves the defined range
  p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
    code <= FN_ALT);
endmodule

// File: rtl/padfn_router.sv
module padfn_router
  import padfn_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [1:0]                 bus_op,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [NUM_PINS-1:0]        bus_wdata,
  output logic [NUM_PINS-1:0]        bus_rdata,
  input  logic [NUM_PINS-1:0]        gpio_do,
  input  logic [NUM_PINS-1:0]        gpio_oe,
  input  logic [NUM_PINS-1:0]        sec_do,
  input  logic [NUM_PINS-1:0]        sec_oe,
  input  logic [NUM_PINS-1:0]        ter_do,
  input  logic [NUM_PINS-1:0]        ter_oe,
  input  logic [NUM_PINS-1:0]        qua_do,
  input  logic [NUM_PINS-1:0]        qua_oe,
  input  logic [NUM_PINS-1:0]        dbg_do,
  input  logic [NUM_PINS-1:0]        dbg_oe,
  input  logic [NUM_PINS-1:0]        alt_do,
  input  logic [NUM_PINS-1:0]        alt_oe,
  input  logic [NUM_PINS-1:0]        pad_di,
  output logic [NUM_PINS-1:0]        pad_do,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_pu,
  output logic [NUM_PINS-1:0]        periph_di,
  output logic [CODE_W*NUM_PINS-1:0] fn_code
);
  logic [NUM_FN-1:0][NUM_PINS-1:0] sel;

  padfn_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .re    (bus_re),
    .op    (bus_op),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .sel_o (sel),
    .pu_o  (pad_pu)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    padfn_pin u_pin (
      .clk    (clk),
      .rst    (rst),
      .sel    ({sel[4][i], sel[3][i], sel[2][i], sel[1][i], sel[0][i]}),
      .src_do ({alt_do[i], dbg_do[i], qua_do[i], ter_do[i], sec_do[i], gpio_do[i]}),
      .src_oe ({alt_oe[i], dbg_oe[i], qua_oe[i], ter_oe[i], sec_oe[i], gpio_oe[i]}),
      .pad_do (pad_do[i]),
      .pad_oe (pad_oe[i]),
      .code   (fn_code[CODE_W*i +: CODE_W])
    );
  end

  assign periph_di = pad_di;
endmodule

// File: tb/sim_padfn_router.sv
module sim_padfn_router;
  localparam int P = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0] bus_op = 2'd0;
  logic [7:0] bus_addr = 8'h00;
  logic [P-1:0] bus_wdata = '0, bus_rdata;
  logic [P-1:0] gpio_do, gpio_oe, sec_do, sec_oe, ter_do, ter_oe;
  logic [P-1:0] qua_do, qua_oe, dbg_do, dbg_oe, alt_do, alt_oe, pad_di;
  logic [P-1:0] pad_do, pad_oe, pad_pu, periph_di;
  logic [3*P-1:0] fn_code;

  int n_chk = 0, n_fail = 0;
  logic [P-1:0] mdl [6];

  always #2 clk = ~clk;

  padfn_router #(.NUM_PINS(P), .ADDR_W(8)) u0 (.*);

  function automatic logic [7:0] offs(int k);
    case (k)
      0: return 8'h14; 1: return 8'h8C; 2: return 8'h94;
      3: return 8'h9C; 4: return 8'hA4; default: return 8'hAC;
    endcase
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3*P-1:0] exp_code();
    logic [3*P-1:0] c = '0;
    for (int i = 0; i < P; i++) begin
      for (int k = 4; k >= 0; k--) if (mdl[k][i]) c[3*i +: 3] = 3'(k + 1);
    end
    return c;
  endfunction

  function automatic logic pick(int c, int i, bit oe);
    case (c)
      0: return oe ? gpio_oe[i] : gpio_do[i];
      1: return oe ? sec_oe[i] : sec_do[i];
      2: return oe ? ter_oe[i] : ter_do[i];
      3: return oe ? qua_oe[i] : qua_do[i];
      4: return oe ? dbg_oe[i] : dbg_do[i];
      default: return oe ? alt_oe[i] : alt_do[i];
    endcase
  endfunction

  task automatic chk_pads(string req);
    logic [3*P-1:0] c = exp_code();
    logic [P-1:0] edo, eoe;
    for (int i = 0; i < P; i++) begin
      edo[i] = pick(int'(c[3*i +: 3]), i, 1'b0);
      eoe[i] = pick(int'(c[3*i +: 3]), i, 1'b1);
    end
    chk({req, " code"}, 128'(fn_code), 128'(c));
    chk({req, " pad_do"}, 128'(pad_do), 128'(edo));
    chk({req, " pad_oe"}, 128'(pad_oe), 128'(eoe));
  endtask

  task automatic bwr(logic [7:0] a, logic [1:0] op, logic [P-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_op = op; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (a == offs(k)) begin
        case (op)
          2'd0: mdl[k] = d;
          2'd1: mdl[k] = mdl[k] | d;
          2'd2: mdl[k] = mdl[k] & ~d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [P-1:0] exp);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    chk(req, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic t_reset;
    for (int k = 0; k < 6; k++) rd_chk("R1 reg", offs(k), '0);
    chk("R1 code", 128'(fn_code), 128'(0));
    chk("R1 pad_do", 128'(pad_do), 128'(gpio_do));
    chk("R1 pad_oe", 128'(pad_oe), 128'(gpio_oe));
    chk("R1 pad_pu", 128'(pad_pu), 128'(0));
  endtask

  task automatic t_full_write;
    for (int k = 0; k < 6; k++) bwr(offs(k), 2'd0, 32'h1111_0000 * (k + 1) + 32'(k));
    for (int k = 0; k < 6; k++) rd_chk("R2 R9 full write", offs(k), mdl[k]);
    rd_chk("R9 unmapped read", 8'h00, '0);
    for (int k = 0; k < 6; k++) bwr(offs(k), 2'd0, '0);
  endtask

  task automatic t_setclr;
    bwr(offs(2), 2'd0, 32'h0000_FF00);
    bwr(offs(2), 2'd1, 32'h0F0F_0F0F);
    rd_chk("R3 set-mask", offs(2), 32'h0F0F_FF0F);
    bwr(offs(2), 2'd2, 32'h0000_3C0F);
    rd_chk("R3 clear-mask", offs(2), 32'h0F0F_C300);
    bwr(offs(2), 2'd3, 32'hFFFF_FFFF);
    rd_chk("R3 op3 no effect", offs(2), 32'h0F0F_C300);
    chk_pads("R3");
    bwr(offs(2), 2'd0, '0);
  endtask

  task automatic t_priority;
    // pin i has select k set iff bit k of i is 1: all 32 combinations
    bwr(offs(0), 2'd0, 32'hAAAA_AAAA);
    bwr(offs(1), 2'd0, 32'hCCCC_CCCC);
    bwr(offs(2), 2'd0, 32'hF0F0_F0F0);
    bwr(offs(3), 2'd0, 32'hFF00_FF00);
    bwr(offs(4), 2'd0, 32'hFFFF_0000);
    chk_pads("R4 R5 R6 all combos");
    chk("R5 pin16 alt", 128'(fn_code[48 +: 3]), 128'(5));
    chk("R5 pin0 gpio", 128'(fn_code[0 +: 3]), 128'(0));
    chk("R4 pin31 sec", 128'(fn_code[93 +: 3]), 128'(1));
    bwr(offs(0), 2'd2, 32'hFFFF_FFFF);
    chk_pads("R4 secondary cleared");
  endtask

  task automatic t_comb;
    #1;
    gpio_do = ~gpio_do; sec_do = ~sec_do; ter_oe = ~ter_oe; alt_do = ~alt_do;
    #0.5;
    chk_pads("R6 same-cycle source change");
    @(negedge clk);
    for (int k = 0; k < 5; k++) bwr(offs(k), 2'd0, '0);
    chk_pads("R6 back to gpio");
  endtask

  task automatic t_bcast;
    pad_di = 32'h5A5A_C3C3;
    #1 chk("R7 broadcast", 128'(periph_di), 128'(32'h5A5A_C3C3));
    pad_di = 32'h1234_8765;
    #1 chk("R7 broadcast change", 128'(periph_di), 128'(32'h1234_8765));
    @(negedge clk);
  endtask

  task automatic t_pull;
    bwr(8'hAC, 2'd0, 32'h8001_0240);
    chk("R8 pull-up", 128'(pad_pu), 128'(32'h8001_0240));
    bwr(8'hAC, 2'd2, 32'h0000_0040);
    chk("R8 pull-up clear", 128'(pad_pu), 128'(32'h8001_0200));
  endtask

  task automatic t_unmapped;
    bwr(8'h18, 2'd0, 32'hFFFF_FFFF);
    bwr(8'h90, 2'd1, 32'hFFFF_FFFF);
    bwr(8'hA8, 2'd0, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) rd_chk("R10 unmapped write", offs(k), mdl[k]);
    chk_pads("R10");
  endtask

  initial begin
    for (int k = 0; k < 6; k++) mdl[k] = '0;
    gpio_do = 32'h0F0F_1234; gpio_oe = 32'hFFFF_0000;
    sec_do  = 32'h3333_AAAA; sec_oe  = 32'h00FF_00FF;
    ter_do  = 32'h5555_0F0F; ter_oe  = 32'hF0F0_F0F0;
    qua_do  = 32'h6969_9696; qua_oe  = 32'h0F0F_0F0F;
    dbg_do  = 32'hC3C3_3C3C; dbg_oe  = 32'hAAAA_5555;
    alt_do  = 32'h8421_1248; alt_oe  = 32'h5555_AAAA;
    pad_di  = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_setclr();
    t_priority();
    t_comb();
    t_bcast();
    t_pull();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule